// File: doc/BRIEF.md
# VGA Sync Timing Generator

This block produces the raster timing for a VGA display. A pixel-clock enable advances a horizontal position counter through four line phases: active, front porch, sync, back porch. At the end of each line a vertical counter advances through the same four phases, counted in lines. From these two positions the block derives horizontal and vertical sync, the blanking flags, the active-video flag, the current pixel and line numbers, and a one-cycle frame-done pulse.

Each sync has its own polarity bit. Either sync pin can also carry a composite of both syncs. A rectangular window inside the visible area marks the picture. Visible pixels outside that window are flagged as border and carry a 24-bit RGB colour. The timing and window fields are copied into shadow registers only at frame boundaries, so the controlling logic can rewrite them at any time without tearing the frame in progress.

Top module: `vga_sync_gen`

## Requirements
- R1: A line consists of (cfg_ppl+1)*16 active pixels, then cfg_hfp+1 front-porch pixels, then cfg_hsw+1 sync pixels, then cfg_hbp+1 back-porch pixels. pix_x counts 0 upward from the first active pixel and returns to 0 after the last back-porch pixel.
- R2: A frame consists of cfg_lps+1 active lines, then cfg_vfp front-porch lines (zero allowed), then cfg_vsw+1 sync lines, then cfg_vbp back-porch lines (zero allowed). line_y counts 0 upward from the first active line.
- R3: Both positions advance by one pixel only on clock edges where pix_en is 1. With pix_en at 0 the position and every output derived from it hold.
- R4: The internal sync is true during its sync phase. With the polarity bit at 1 the pin is high while the sync is true. With the polarity bit at 0 the pin is low while the sync is true, and high otherwise.
- R5: With cfg_vcomp at 1, vsync_o carries the XNOR of the two polarity-applied sync levels when cfg_vpos_pol is 0, and their XOR when cfg_vpos_pol is 1.
- R6: With cfg_hcomp at 1, hsync_o carries the AND of the two polarity-applied sync levels when cfg_hpos_pol is 0, and their NAND when cfg_hpos_pol is 1.
- R7: The picture window covers pixels whose pix_x/4 lies in [cfg_win_hs, cfg_win_he) and whose line_y/4 lies in [cfg_win_vs, cfg_win_ve). border_o is 1 on active pixels outside the window. border_rgb_o equals cfg_border_rgb while border_o is 1, and is 0 otherwise.
- R8: frame_done_o is high for exactly one cycle per frame. That cycle is the one in which pix_en is 1 on the last back-porch pixel of the last back-porch line. The next position is (0,0).
- R9: The timing and window fields are sampled in the first cycle after reset and on each frame_done_o cycle. A change made in the middle of a frame takes effect only at the start of the next frame. Polarity, composite and colour inputs act at once.
- R10: While reset is low, pix_x and line_y are 0 and frame_done_o is 0. The first clock after reset loads the fields and does not advance the position, even with pix_en at 1.
- R11: active_o is 1 exactly when pix_x is below the active width and line_y is below the active line count. hblank_o and vblank_o flag the non-active part of each axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Pixel-clock enable |
| cfg_ppl | input | 6 | Active width / 16, minus one |
| cfg_hsw | input | 8 | Horizontal sync pixels minus one |
| cfg_hfp | input | 8 | Horizontal front porch pixels minus one |
| cfg_hbp | input | 8 | Horizontal back porch pixels minus one |
| cfg_lps | input | 10 | Active lines minus one |
| cfg_vsw | input | 6 | Vertical sync lines minus one |
| cfg_vfp | input | 8 | Vertical front porch lines |
| cfg_vbp | input | 8 | Vertical back porch lines |
| cfg_hpos_pol | input | 1 | Horizontal sync polarity, 1 = positive |
| cfg_vpos_pol | input | 1 | Vertical sync polarity, 1 = positive |
| cfg_vcomp | input | 1 | Composite sync on vsync_o |
| cfg_hcomp | input | 1 | Composite sync on hsync_o |
| cfg_win_hs | input | 8 | Window start column, in 4-pixel units |
| cfg_win_he | input | 8 | Window end column (exclusive), in 4-pixel units |
| cfg_win_vs | input | 8 | Window start row, in 4-line units |
| cfg_win_ve | input | 8 | Window end row (exclusive), in 4-line units |
| cfg_border_rgb | input | 24 | Border colour, RGB 8:8:8 |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |
| active_o | output | 1 | Visible pixel |
| border_o | output | 1 | Visible pixel outside the window |
| border_rgb_o | output | 24 | Border colour while border_o, else 0 |
| pix_x | output | 11 | Current pixel position in the line |
| line_y | output | 11 | Current line in the frame |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
Three timing sets with different widths, porches and sync lengths each run for one full frame. Per-frame counts of sync-high, vertical-sync and active cycles separate errors in the phase lengths from errors in the phase order. One of these sets has zero-length vertical porches, and one has a single active line. The composite modes run over one frame with the sync overlap on one known line. The low-cycle counts differ for XNOR, AND and NAND, so a swapped gate or a wrong polarity gives a different number. A run with pix_en toggling, a window that leaves a known border area, and a field change in the middle of a frame test stalling, border colouring and the frame-boundary update.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
    localparam int PPL_W     = 6;
    localparam int PORCH_W   = 8;
    localparam int LPS_W     = 10;
    localparam int VSW_W     = 6;
    localparam int WIN_W     = 8;
    localparam int RGB_W     = 24;
    localparam int PIX_GRAIN = 4;   // log2 of the active-width unit
    localparam int WIN_GRAIN = 2;   // log2 of the window unit
    localparam int HPOS_W    = PPL_W + PIX_GRAIN + 1;
    localparam int VPOS_W    = LPS_W + 1;

    typedef struct packed {
        logic [PPL_W-1:0]   ppl;
        logic [PORCH_W-1:0] hsw;
        logic [PORCH_W-1:0] hfp;
        logic [PORCH_W-1:0] hbp;
        logic [LPS_W-1:0]   lps;
        logic [VSW_W-1:0]   vsw;
        logic [PORCH_W-1:0] vfp;
        logic [PORCH_W-1:0] vbp;
        logic [WIN_W-1:0]   win_hs;
        logic [WIN_W-1:0]   win_he;
        logic [WIN_W-1:0]   win_vs;
        logic [WIN_W-1:0]   win_ve;
    } vsg_cfg_t;

    typedef struct packed {
        logic [HPOS_W-1:0] act_end;
        logic [HPOS_W-1:0] fp_end;
        logic [HPOS_W-1:0] sync_end;
        logic [HPOS_W-1:0] last;
    } vsg_hspan_t;

    typedef struct packed {
        logic [VPOS_W-1:0] act_end;
        logic [VPOS_W-1:0] fp_end;
        logic [VPOS_W-1:0] sync_end;
        logic [VPOS_W-1:0] last;
    } vsg_vspan_t;
endpackage

// File: rtl/vsg_spans.sv
module vsg_spans
    import vsg_pkg::*;
(
    input  vsg_cfg_t   cfg,
    output vsg_hspan_t hspan,
    output vsg_vspan_t vspan
);
    always_comb begin
        hspan.act_end  = (HPOS_W'(cfg.ppl) + HPOS_W'(1)) << PIX_GRAIN;
        hspan.fp_end   = hspan.act_end + HPOS_W'(cfg.hfp) + HPOS_W'(1);
        hspan.sync_end = hspan.fp_end + HPOS_W'(cfg.hsw) + HPOS_W'(1);
        hspan.last     = hspan.sync_end + HPOS_W'(cfg.hbp);

        vspan.act_end  = VPOS_W'(cfg.lps) + VPOS_W'(1);
        vspan.fp_end   = vspan.act_end + VPOS_W'(cfg.vfp);
        vspan.sync_end = vspan.fp_end + VPOS_W'(cfg.vsw) + VPOS_W'(1);
        vspan.last     = vspan.sync_end + VPOS_W'(cfg.vbp) - VPOS_W'(1);
    end
endmodule

// File: rtl/vsg_counter.sv
module vsg_counter #(
    parameter int XW = 11,
    parameter int YW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [XW-1:0] x_last,
    input  logic [YW-1:0] y_last,
    output logic [XW-1:0] pos_x,
    output logic [YW-1:0] pos_y,
    output logic          frame_end
);
    typedef struct packed {
        logic [XW-1:0] x;
        logic [YW-1:0] y;
    } pos_t;

    pos_t pos_d, pos_q;
    logic line_end;

    always_comb begin
        pos_d     = pos_q;
        line_end  = (pos_q.x == x_last);
        frame_end = step && line_end && (pos_q.y == y_last);
        if (step) begin
            if (line_end) begin
                pos_d.x = '0;
                pos_d.y = (pos_q.y == y_last) ? '0 : pos_q.y + YW'(1);
            end else begin
                pos_d.x = pos_q.x + XW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign pos_x = pos_q.x;
    assign pos_y = pos_q.y;
endmodule

// File: rtl/vsg_pins.sv
module vsg_pins
    import vsg_pkg::*;
(
    input  logic [HPOS_W-1:0] pos_x,
    input  logic [VPOS_W-1:0] pos_y,
    input  vsg_hspan_t        hspan,
    input  vsg_vspan_t        vspan,
    input  vsg_cfg_t          cfg,
    input  logic              hpol,
    input  logic              vpol,
    input  logic              hcomp,
    input  logic              vcomp,
    input  logic [RGB_W-1:0]  rgb,
    output logic              hsync_pin,
    output logic              vsync_pin,
    output logic              hblank,
    output logic              vblank,
    output logic              active,
    output logic              border,
    output logic [RGB_W-1:0]  border_rgb
);
    localparam int XC_W = HPOS_W - WIN_GRAIN;
    localparam int YC_W = VPOS_W - WIN_GRAIN;

    logic [1:0] sync_raw;
    logic [1:0] sync_pol;
    logic [1:0] sync_lvl;
    logic [XC_W-1:0] xc;
    logic [YC_W-1:0] yc;
    logic in_win;

    assign sync_raw[0] = (pos_x >= hspan.fp_end) && (pos_x < hspan.sync_end);
    assign sync_raw[1] = (pos_y >= vspan.fp_end) && (pos_y < vspan.sync_end);
    assign sync_pol    = {vpol, hpol};

    for (genvar a = 0; a < 2; a++) begin : g_axis
        assign sync_lvl[a] = sync_pol[a] ? sync_raw[a] : ~sync_raw[a];
    end

    always_comb begin
        if (hcomp) hsync_pin = hpol ? ~(sync_lvl[0] & sync_lvl[1]) : (sync_lvl[0] & sync_lvl[1]);
        else       hsync_pin = sync_lvl[0];
        if (vcomp) vsync_pin = vpol ? (sync_lvl[0] ^ sync_lvl[1]) : ~(sync_lvl[0] ^ sync_lvl[1]);
        else       vsync_pin = sync_lvl[1];
    end

    assign hblank = (pos_x >= hspan.act_end);
    assign vblank = (pos_y >= vspan.act_end);
    assign active = (pos_x < hspan.act_end) && (pos_y < vspan.act_end);

    assign xc     = pos_x[HPOS_W-1:WIN_GRAIN];
    assign yc     = pos_y[VPOS_W-1:WIN_GRAIN];
    assign in_win = (xc >= XC_W'(cfg.win_hs)) && (xc < XC_W'(cfg.win_he)) &&
                    (yc >= YC_W'(cfg.win_vs)) && (yc < YC_W'(cfg.win_ve));

    assign border     = active && !in_win;
    assign border_rgb = border ? rgb : '0;
endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen
    import vsg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_en,
    input  logic [PPL_W-1:0]   cfg_ppl,
    input  logic [PORCH_W-1:0] cfg_hsw,
    input  logic [PORCH_W-1:0] cfg_hfp,
    input  logic [PORCH_W-1:0] cfg_hbp,
    input  logic [LPS_W-1:0]   cfg_lps,
    input  logic [VSW_W-1:0]   cfg_vsw,
    input  logic [PORCH_W-1:0] cfg_vfp,
    input  logic [PORCH_W-1:0] cfg_vbp,
    input  logic               cfg_hpos_pol,
    input  logic               cfg_vpos_pol,
    input  logic               cfg_vcomp,
    input  logic               cfg_hcomp,
    input  logic [WIN_W-1:0]   cfg_win_hs,
    input  logic [WIN_W-1:0]   cfg_win_he,
    input  logic [WIN_W-1:0]   cfg_win_vs,
    input  logic [WIN_W-1:0]   cfg_win_ve,
    input  logic [RGB_W-1:0]   cfg_border_rgb,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               hblank_o,
    output logic               vblank_o,
    output logic               active_o,
    output logic               border_o,
    output logic [RGB_W-1:0]   border_rgb_o,
    output logic [HPOS_W-1:0]  pix_x,
    output logic [VPOS_W-1:0]  line_y,
    output logic               frame_done_o
);
    typedef struct packed {
        vsg_cfg_t cfg;
        logic     load;
    } shadow_t;

    shadow_t    st_d, st_q;
    vsg_cfg_t   cfg_in;
    vsg_hspan_t hspan;
    vsg_vspan_t vspan;
    logic       step;
    logic       frame_end;
    logic       loading;

    always_comb begin
        cfg_in.ppl    = cfg_ppl;
        cfg_in.hsw    = cfg_hsw;
        cfg_in.hfp    = cfg_hfp;
        cfg_in.hbp    = cfg_hbp;
        cfg_in.lps    = cfg_lps;
        cfg_in.vsw    = cfg_vsw;
        cfg_in.vfp    = cfg_vfp;
        cfg_in.vbp    = cfg_vbp;
        cfg_in.win_hs = cfg_win_hs;
        cfg_in.win_he = cfg_win_he;
        cfg_in.win_vs = cfg_win_vs;
        cfg_in.win_ve = cfg_win_ve;
    end

    // Shadow copy: refreshed after reset and at each frame boundary.
    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        if (st_q.load || frame_end) st_d.cfg = cfg_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= '0;
            st_q.load <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign loading = st_q.load;
    assign step    = pix_en && !st_q.load;

    vsg_spans u_spans (
        .cfg   (st_q.cfg),
        .hspan (hspan),
        .vspan (vspan)
    );

    vsg_counter #(.XW(HPOS_W), .YW(VPOS_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .x_last    (hspan.last),
        .y_last    (vspan.last),
        .pos_x     (pix_x),
        .pos_y     (line_y),
        .frame_end (frame_end)
    );

    vsg_pins u_pins (
        .pos_x      (pix_x),
        .pos_y      (line_y),
        .hspan      (hspan),
        .vspan      (vspan),
        .cfg        (st_q.cfg),
        .hpol       (cfg_hpos_pol),
        .vpol       (cfg_vpos_pol),
        .hcomp      (cfg_hcomp),
        .vcomp      (cfg_vcomp),
        .rgb        (cfg_border_rgb),
        .hsync_pin  (hsync_o),
        .vsync_pin  (vsync_o),
        .hblank     (hblank_o),
        .vblank     (vblank_o),
        .active     (active_o),
        .border     (border_o),
        .border_rgb (border_rgb_o)
    );

    assign frame_done_o = frame_end;
endmodule

// File: rtl/vga_sync_gen_chk.sv
module vga_sync_gen_chk #(
    parameter int HW = 11,
    parameter int VW = 11,
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_en,
    input logic          load,
    input logic [HW-1:0] pix_x,
    input logic [VW-1:0] line_y,
    input logic          frame_done_o,
    input logic          active_o,
    input logic          border_o,
    input logic [CW-1:0] border_rgb_o
);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(pix_x) && $stable(line_y));

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && !load && !frame_done_o) |=>
            (pix_x == $past(pix_x) + HW'(1) && line_y == $past(line_y)) ||
            (pix_x == '0 && line_y == $past(line_y) + VW'(1)));

    p_done_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> (pix_x == '0 && line_y == '0));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    p_load_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pix_x == '0 && line_y == '0));

    p_border_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
        border_o |-> active_o);

    p_rgb_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (border_rgb_o != '0) |-> border_o);

    p_origin_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_x == '0 && line_y == '0) |-> active_o);
endmodule

bind vga_sync_gen vga_sync_gen_chk #(
    .HW(vsg_pkg::HPOS_W), .VW(vsg_pkg::VPOS_W), .CW(vsg_pkg::RGB_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_en       (pix_en),
    .load         (loading),
    .pix_x        (pix_x),
    .line_y       (line_y),
    .frame_done_o (frame_done_o),
    .active_o     (active_o),
    .border_o     (border_o),
    .border_rgb_o (border_rgb_o)
);

// File: tb/vga_sync_gen_test.sv
`timescale 1ns/1ps
module vga_sync_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic [5:0]  cfg_ppl = '0;
    logic [7:0]  cfg_hsw = '0, cfg_hfp = '0, cfg_hbp = '0;
    logic [9:0]  cfg_lps = '0;
    logic [5:0]  cfg_vsw = '0;
    logic [7:0]  cfg_vfp = '0, cfg_vbp = '0;
    logic        cfg_hpos_pol = 1'b1, cfg_vpos_pol = 1'b1;
    logic        cfg_vcomp = 1'b0, cfg_hcomp = 1'b0;
    logic [7:0]  cfg_win_hs = 8'd0, cfg_win_he = 8'd255;
    logic [7:0]  cfg_win_vs = 8'd0, cfg_win_ve = 8'd255;
    logic [23:0] cfg_border_rgb = 24'h3C_A5_7E;

    logic        hsync_o, vsync_o, hblank_o, vblank_o, active_o, border_o, frame_done_o;
    logic [23:0] border_rgb_o;
    logic [10:0] pix_x, line_y;

    vga_sync_gen uut (.*);

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [5:0]  ppl;
        logic [7:0]  hfp;
        logic [7:0]  hsw;
        logic [7:0]  hbp;
        logic [9:0]  lps;
        logic [7:0]  vfp;
        logic [5:0]  vsw;
        logic [7:0]  vbp;
        logic [15:0] frame;
        logic [15:0] hs;
        logic [15:0] act;
        logic [15:0] vs;
    } vec_t;

    localparam vec_t VECS [3] = '{
        '{6'd0, 8'd1, 8'd2, 8'd0, 10'd3, 8'd1, 6'd0, 8'd2, 16'd176, 16'd24, 16'd64, 16'd22},
        '{6'd1, 8'd0, 8'd0, 8'd3, 10'd1, 8'd0, 6'd2, 8'd0, 16'd190, 16'd5,  16'd64, 16'd114},
        '{6'd2, 8'd4, 8'd7, 8'd1, 10'd0, 8'd3, 6'd1, 8'd1, 16'd441, 16'd56, 16'd48, 16'd126}
    };

    int n_checks = 0, n_errors = 0;
    int c_hs_hi, c_hs_lo, c_vs_hi, c_vs_lo, c_act, c_brd, c_done, done_idx;
    int first_x, p_x, p_y;
    logic [23:0] p_rgb, q_rgb;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_timing(input vec_t v);
        cfg_ppl = v.ppl; cfg_hfp = v.hfp; cfg_hsw = v.hsw; cfg_hbp = v.hbp;
        cfg_lps = v.lps; cfg_vfp = v.vfp; cfg_vsw = v.vsw; cfg_vbp = v.vbp;
    endtask

    task automatic do_reset(input bit check_state);
        @(negedge clk);
        rst_n  = 1'b0;
        pix_en = 1'b1;
        repeat (2) @(negedge clk);
        #0.5;
        if (check_state) begin
            chk("R10 pix_x in reset", int'(pix_x), 0);
            chk("R10 line_y in reset", int'(line_y), 0);
            chk("R10 frame_done in reset", int'(frame_done_o), 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic run(input int n, input bit alt, input int probe);
        c_hs_hi = 0; c_hs_lo = 0; c_vs_hi = 0; c_vs_lo = 0;
        c_act = 0; c_brd = 0; c_done = 0; done_idx = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_en = alt ? (i % 2 == 0) : 1'b1;
            #0.5;
            if (hsync_o) c_hs_hi++; else c_hs_lo++;
            if (vsync_o) c_vs_hi++; else c_vs_lo++;
            if (active_o) c_act++;
            if (border_o) c_brd++;
            if (frame_done_o) begin c_done++; done_idx = i; end
            if (i == 0) first_x = int'(pix_x);
            if (i == probe) begin p_x = int'(pix_x); p_y = int'(line_y); p_rgb = border_rgb_o; end
            if (i == probe + 4) q_rgb = border_rgb_o;
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        // Table walk: one frame per timing set, positive syncs, full window
        foreach (VECS[k]) begin
            set_timing(VECS[k]);
            do_reset(k == 0);
            run(int'(VECS[k].frame), 1'b0, -1);
            chk("R10 no step on load cycle", first_x, 0);
            chk("R1 hsync pixels per frame", c_hs_hi, int'(VECS[k].hs));
            chk("R2 vsync pixels per frame", c_vs_hi, int'(VECS[k].vs));
            chk("R11 active pixels per frame", c_act, int'(VECS[k].act));
            chk("R8 one done pulse", c_done, 1);
            chk("R8 done on last pixel", done_idx, int'(VECS[k].frame) - 1);
            chk("R7 no border with full window", c_brd, 0);
        end

        // Position probe: 22-pixel lines, sample 117 is line 5 pixel 7
        set_timing(VECS[0]);
        do_reset(1'b0);
        run(176, 1'b0, 117);
        chk("R1 pix_x at probe", p_x, 7);
        chk("R2 line_y at probe", p_y, 5);

        // Negative polarity
        cfg_hpos_pol = 1'b0; cfg_vpos_pol = 1'b0;
        run(176, 1'b0, -1);
        chk("R4 hsync low cycles", c_hs_lo, 24);
        chk("R4 vsync low cycles", c_vs_lo, 22);

        // Composite on vsync, XNOR form
        cfg_vcomp = 1'b1;
        run(176, 1'b0, -1);
        chk("R5 composite XNOR low cycles", c_vs_lo, 40);
        cfg_vpos_pol = 1'b1; cfg_hpos_pol = 1'b1;
        run(176, 1'b0, -1);
        chk("R5 composite XOR high cycles", c_vs_hi, 40);
        cfg_vcomp = 1'b0;

        // Composite on hsync, AND then NAND form
        cfg_hcomp = 1'b1; cfg_hpos_pol = 1'b0; cfg_vpos_pol = 1'b0;
        run(176, 1'b0, -1);
        chk("R6 composite AND low cycles", c_hs_lo, 43);
        cfg_hpos_pol = 1'b1; cfg_vpos_pol = 1'b1;
        run(176, 1'b0, -1);
        chk("R6 composite NAND low cycles", c_hs_lo, 3);
        cfg_hcomp = 1'b0;

        // Stalling enable
        run(352, 1'b1, -1);
        chk("R3 one done over stalled frame", c_done, 1);
        chk("R3 done on last enabled cycle", done_idx, 350);
        chk("R3 hsync samples doubled", c_hs_hi, 48);

        // Border window: columns 4..11, all active lines
        cfg_win_hs = 8'd1; cfg_win_he = 8'd3; cfg_win_vs = 8'd0; cfg_win_ve = 8'd1;
        do_reset(1'b0);
        run(176, 1'b0, 0);
        chk("R7 border pixels", c_brd, 32);
        chk("R7 border colour at x=0", int'(p_rgb), int'(24'h3C_A5_7E));
        chk("R7 no colour inside window", int'(q_rgb), 0);

        // Mid-frame change applies at the next frame
        run(50, 1'b0, -1);
        set_timing(VECS[1]);
        run(126, 1'b0, -1);
        chk("R9 old frame length kept", done_idx, 125);
        chk("R9 one done in old frame", c_done, 1);
        run(190, 1'b0, -1);
        chk("R9 new frame length", done_idx, 189);
        chk("R9 new hsync count", c_hs_hi, 5);

        finish_run();
    end
endmodule